// File: doc/BRIEF.md
# Flag-delimited byte-stream frame receiver

This block recovers packets from a serial byte stream in which a reserved flag byte (0x7E) separates frames and an escape byte (0x7D) protects data bytes that would otherwise collide with the reserved values. Bytes arrive one per cycle in which a valid strobe is high, typically straight from a UART receiver. The block removes the escapes and the flags. It delivers the recovered payload one byte at a time, with markers for the first and the final byte of each frame. It also raises a one-cycle pulse when a frame closes cleanly and a one-cycle error pulse when a frame is aborted.

Only the reserved flag value resynchronises the receiver. After reset, after a frame that grew past the configured maximum length, or in any other state of doubt, every byte is thrown away until a flag arrives. An escaped byte is restored by inverting bit 5. The end of a frame is known only when its closing flag arrives, so the receiver keeps one recovered byte in reserve. The final byte can then carry its last marker. Frame check sequences, storage of whole frames and parsing of the payload are left to downstream logic.

Top module: `flag_frame_rx`

## Requirements
- R1: After reset all outputs are low. Every byte received before the first flag (0x7E) is discarded and produces no output.
- R2: A data byte (neither 0x7E nor 0x7D) is held inside the block. It appears on outByte with outValid high in the cycle after the next data byte or the closing flag is accepted.
- R3: An escape byte 0x7D is never output. The byte that follows it (unless it is 0x7E) is output as that byte XOR 0x20, so 0x7D 0x5E yields 0x7E and 0x7D 0x5D yields 0x7D.
- R4: A flag that follows at least one data byte emits the held byte with outLast high and frameDone high in the same cycle. The same flag opens the next frame.
- R5: Consecutive flags with no data byte between them produce no output and no frameDone.
- R6: outFirst is high on the first output byte of every frame and on no other. A one-byte frame has outFirst and outLast both high on its only byte.
- R7: An escape byte directly followed by a flag aborts the frame. frameErr pulses, the held byte is dropped without outLast, and the flag opens a new frame.
- R8: A frame may hold at most MAX_LEN data bytes. A frame of exactly MAX_LEN bytes closes normally. The next data byte beyond the limit pulses frameErr and drops the held byte, and all bytes up to the next flag are discarded.
- R9: frameDone and frameErr are never high in the same cycle. frameDone is high only together with outValid and outLast.
- R10: In cycles with inValid low the outputs stay low in the following cycle, and the frame being collected is not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | inByte carries a received byte this cycle |
| inByte | input | BYTE_W | Received stream byte |
| outValid | output | 1 | outByte carries a recovered payload byte |
| outByte | output | BYTE_W | Recovered payload byte |
| outFirst | output | 1 | First byte of a frame |
| outLast | output | 1 | Final byte of a cleanly closed frame |
| frameDone | output | 1 | One-cycle pulse: a non-empty frame closed cleanly |
| frameErr | output | 1 | One-cycle pulse: a frame was aborted (escape before flag, or overlength) |

## Verification
On every cycle the assertions check the following. The status pulses never coincide, and a clean close always comes with the last byte. The length count stays within MAX_LEN and is zero whenever no byte is held back. The hunting state emits nothing. An escaped position never lasts beyond one accepted byte, and idle input cycles never cause strobes. Only the bench scenarios can show that the values are right. They check the XOR restoration, the exact cycle each held byte leaves, the first and last markers on one-byte and many-byte frames, the behaviour at exactly MAX_LEN and one byte past it, and the discarding of bytes until a flag after reset and after an overlength abort.

// File: rtl/flag_frame_pkg.sv
package flag_frame_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_OPEN = 2'd1,
    ST_ESC  = 2'd2
  } rxState_t;

  typedef struct packed {
    logic push;   // accept a payload byte into the hold slot
    logic unesc;  // pushed byte must have its flip mask applied
    logic flush;  // emit held byte as the final one of the frame
    logic drop;   // discard held byte and restart the length count
    logic done;   // clean frame close
    logic err;    // frame abort
  } rxStrobe_t;

endpackage

// File: rtl/ffr_ctrl.sv
module ffr_ctrl
  import flag_frame_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] FLAG_CODE = 'h7E,
  parameter logic [BYTE_W-1:0] ESC_CODE  = 'h7D
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              holding,
  input  logic              lenFull,
  output rxStrobe_t         strb
);

  rxState_t state, nextState;
  logic isFlag, isEsc;

  assign isFlag = (inByte == FLAG_CODE);
  assign isEsc  = (inByte == ESC_CODE);

  always_comb begin
    strb      = '0;
    nextState = state;
    if (inValid) begin
      case (state)
        ST_HUNT: begin
          if (isFlag) begin
            strb.drop = 1'b1;
            nextState = ST_OPEN;
          end
        end
        ST_OPEN: begin
          if (isFlag) begin
            if (holding) begin
              strb.flush = 1'b1;
              strb.done  = 1'b1;
            end
          end else if (isEsc) begin
            nextState = ST_ESC;
          end else if (lenFull) begin
            strb.err  = 1'b1;
            strb.drop = 1'b1;
            nextState = ST_HUNT;
          end else begin
            strb.push = 1'b1;
          end
        end
        ST_ESC: begin
          if (isFlag) begin
            strb.err  = 1'b1;
            strb.drop = 1'b1;
            nextState = ST_OPEN;
          end else if (lenFull) begin
            strb.err  = 1'b1;
            strb.drop = 1'b1;
            nextState = ST_HUNT;
          end else begin
            strb.push  = 1'b1;
            strb.unesc = 1'b1;
            nextState  = ST_OPEN;
          end
        end
        default: nextState = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_HUNT;
    else       state <= nextState;
  end

  // R10: an idle input cycle issues no strobe at all
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> (strb == '0));

  // R1: while hunting for a flag nothing is collected or emitted
  p_hunt_silent_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HUNT) |-> (!strb.push && !strb.flush));

  // R3: an escape covers exactly one following accepted byte
  p_esc_one_byte_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ESC && inValid) |=> (state != ST_ESC));

endmodule

// File: rtl/ffr_data.sv
module ffr_data
  import flag_frame_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int MAX_LEN = 64,
  parameter logic [BYTE_W-1:0] FLIP_MASK = 'h20,
  localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] inByte,
  input  rxStrobe_t         strb,
  output logic              holding,
  output logic              lenFull,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte,
  output logic              outFirst,
  output logic              outLast,
  output logic              frameDone,
  output logic              frameErr
);

  logic [BYTE_W-1:0] holdByte;
  logic              holdFirst;
  logic [LEN_W-1:0]  lenCnt;
  logic [BYTE_W-1:0] pushByte;

  assign pushByte = strb.unesc ? (inByte ^ FLIP_MASK) : inByte;
  assign lenFull  = (lenCnt == LEN_W'(MAX_LEN));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdByte  <= '0;
      holdFirst <= 1'b0;
      holding   <= 1'b0;
      lenCnt    <= '0;
      outValid  <= 1'b0;
      outByte   <= '0;
      outFirst  <= 1'b0;
      outLast   <= 1'b0;
      frameDone <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      outValid  <= 1'b0;
      outFirst  <= 1'b0;
      outLast   <= 1'b0;
      frameDone <= strb.done;
      frameErr  <= strb.err;
      if (strb.push) begin
        if (holding) begin
          outValid <= 1'b1;
          outByte  <= holdByte;
          outFirst <= holdFirst;
        end
        holdByte  <= pushByte;
        holdFirst <= !holding;
        holding   <= 1'b1;
        lenCnt    <= lenCnt + LEN_W'(1);
      end
      if (strb.flush) begin
        outValid <= 1'b1;
        outByte  <= holdByte;
        outFirst <= holdFirst;
        outLast  <= 1'b1;
        holding  <= 1'b0;
        lenCnt   <= '0;
      end
      if (strb.drop) begin
        holding <= 1'b0;
        lenCnt  <= '0;
      end
    end
  end

  // R4: a clean close is always carried by the last payload byte
  p_done_has_last_r4: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (outValid && outLast));

  // R9: clean close and abort are exclusive
  p_status_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(frameDone && frameErr));

  // R8: the length count never passes the configured limit
  p_len_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    lenCnt <= LEN_W'(MAX_LEN));

  // R2: a non-zero length always means a byte is held back
  p_len_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !holding |-> (lenCnt == '0));

  // R7: an aborted frame never reports a final byte
  p_err_no_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> !outLast);

endmodule

// File: rtl/flag_frame_rx.sv
module flag_frame_rx
  import flag_frame_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int MAX_LEN = 64,
  parameter logic [BYTE_W-1:0] FLAG_CODE = 'h7E,
  parameter logic [BYTE_W-1:0] ESC_CODE  = 'h7D,
  parameter logic [BYTE_W-1:0] FLIP_MASK = 'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inByte,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte,
  output logic              outFirst,
  output logic              outLast,
  output logic              frameDone,
  output logic              frameErr
);

  rxStrobe_t strb;
  logic      holding;
  logic      lenFull;

  ffr_ctrl #(
    .BYTE_W   (BYTE_W),
    .FLAG_CODE(FLAG_CODE),
    .ESC_CODE (ESC_CODE)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .inByte (inByte),
    .holding(holding),
    .lenFull(lenFull),
    .strb   (strb)
  );

  ffr_data #(
    .BYTE_W   (BYTE_W),
    .MAX_LEN  (MAX_LEN),
    .FLIP_MASK(FLIP_MASK)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .inByte   (inByte),
    .strb     (strb),
    .holding  (holding),
    .lenFull  (lenFull),
    .outValid (outValid),
    .outByte  (outByte),
    .outFirst (outFirst),
    .outLast  (outLast),
    .frameDone(frameDone),
    .frameErr (frameErr)
  );

endmodule

// File: tb/sim_flag_frame_rx.sv
module sim_flag_frame_rx;

  localparam int MAXL = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic       outValid, outFirst, outLast, frameDone, frameErr;
  logic [7:0] outByte;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flag_frame_rx #(.BYTE_W(8), .MAX_LEN(MAXL)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .outValid(outValid), .outByte(outByte), .outFirst(outFirst),
    .outLast(outLast), .frameDone(frameDone), .frameErr(frameErr)
  );

  // behavioural reference: 0 = hunting, 1 = inside frame, 2 = after escape
  int       mMode = 0;
  bit [7:0] mQ[$];
  bit       eV, eF, eL, eD, eE;
  bit [7:0] eB;

  task automatic modelData(input bit [7:0] d);
    if (mQ.size() == MAXL) begin
      eE = 1; mQ.delete(); mMode = 0;
    end else begin
      if (mQ.size() > 0) begin
        eV = 1; eB = mQ[$]; eF = (mQ.size() == 1);
      end
      mQ.push_back(d);
    end
  endtask

  task automatic modelStep(input bit v, input bit [7:0] b);
    {eV, eF, eL, eD, eE} = '0; eB = 8'h00;
    if (v) begin
      case (mMode)
        0: if (b == 8'h7E) begin mQ.delete(); mMode = 1; end
        1: begin
          if (b == 8'h7E) begin
            if (mQ.size() > 0) begin
              eV = 1; eB = mQ[$]; eF = (mQ.size() == 1); eL = 1; eD = 1;
              mQ.delete();
            end
          end else if (b == 8'h7D) mMode = 2;
          else modelData(b);
        end
        default: begin
          if (b == 8'h7E) begin eE = 1; mQ.delete(); mMode = 1; end
          else begin mMode = 1; modelData(b ^ 8'h20); end
        end
      endcase
    end
  endtask

  task automatic step(input bit v, input bit [7:0] b, input string tag);
    bit [12:0] act, exp;
    inValid = v; inByte = b;
    modelStep(v, b);
    @(negedge clk);
    act = {outValid, outFirst, outLast, frameDone, frameErr, outValid ? outByte : 8'h00};
    exp = {eV, eF, eL, eD, eE, eV ? eB : 8'h00};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: in %0b/%h got v%0b f%0b l%0b d%0b e%0b b%h exp v%0b f%0b l%0b d%0b e%0b b%h",
               tag, v, b, act[12], act[11], act[10], act[9], act[8], act[7:0],
               exp[12], exp[11], exp[10], exp[9], exp[8], exp[7:0]);
    end
  endtask

  task automatic sendSeq(input bit [7:0] s[], input string tag);
    foreach (s[i]) step(1, s[i], tag);
    step(0, 8'h00, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, then garbage before any flag is discarded
    step(0, 8'h00, "R1");
    sendSeq('{8'h11, 8'h22, 8'h7D, 8'h33}, "R1");
    // R2 R4 R6: ordinary multi-byte frame
    sendSeq('{8'h7E, 8'hA1, 8'hB2, 8'hC3, 8'h7E}, "R2");
    // R5: empty frames between consecutive flags
    sendSeq('{8'h7E, 8'h7E, 8'h7E}, "R5");
    // R6: one-byte frame carries first and last together
    sendSeq('{8'h55, 8'h7E}, "R6");
    // R3: escapes restore reserved values and other bytes
    sendSeq('{8'h7D, 8'h5E, 8'h7D, 8'h5D, 8'h33, 8'h7D, 8'h41, 8'h7E}, "R3");
    // R10: idle cycles in the middle of a frame
    step(1, 8'h90, "R10"); step(0, 8'h7E, "R10"); step(0, 8'h91, "R10");
    step(1, 8'h92, "R10"); step(0, 8'h00, "R10"); step(1, 8'h7E, "R10");
    // R4: a closing flag opens the next frame directly
    sendSeq('{8'h12, 8'h7E, 8'h34, 8'h56, 8'h7E}, "R4");
    // R7: escape followed by flag aborts; flag starts a new frame
    sendSeq('{8'h44, 8'h45, 8'h7D, 8'h7E, 8'h66, 8'h7E}, "R7");
    sendSeq('{8'h7D, 8'h7E, 8'h67, 8'h7E}, "R7");
    // R8: exactly MAXL bytes closes cleanly
    for (int i = 0; i < MAXL; i++) step(1, 8'(8'h20 + i), "R8");
    step(1, 8'h7E, "R8");
    // R8: one byte past the limit aborts, then bytes are dropped until a flag
    for (int i = 0; i < MAXL + 1; i++) step(1, 8'(8'h40 + i), "R8");
    sendSeq('{8'h01, 8'h02, 8'h7D, 8'h03, 8'h7E, 8'h0A, 8'h7E}, "R8");
    // R8: overlength through an escaped byte
    step(1, 8'h7E, "R8");
    for (int i = 0; i < MAXL; i++) step(1, 8'(8'h60 + i), "R8");
    sendSeq('{8'h7D, 8'h5E, 8'h7E, 8'hEE, 8'h7E}, "R8");
    // R9: mixed traffic for the exclusive status pulses
    sendSeq('{8'h7E, 8'h7D, 8'h7E, 8'hBB, 8'h7E, 8'h7E}, "R9");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not finish, got hang exp completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule